// File: doc/BRIEF.md
# Waveform Trace Rasterizer

This block colours the pixels of a rectangular scope window placed inside a larger video raster. The raster's horizontal and vertical pixel counters drive it. For each window column it reads one amplitude from an external sample memory. It returns one colour per pixel: the trace, a dotted gray grid, or a black fill. Pixels outside the window take the colour presented on a pass-through input, so the block can sit in an existing video pipeline.

To keep the trace unbroken across steep slopes, each column lights the whole vertical span between its own amplitude and the amplitude of the column to its left. The sample memory is a one-cycle synchronous-read store. The block addresses it one pixel ahead, so each sample arrives in the same cycle as the pixel that uses it. The output colour is registered.

The window origin, size, grid pitch and dot pitch are parameters. Two geometries are refused at elaboration: a window whose bottom edge (vertical origin plus height) reaches the display height, and a window that runs past the display width.

Top module: `wr_scope_raster`

## Requirements
- R1: `rgb_o` is a register that shows the colour for the counter values presented one clock earlier, and it reads 0 while `rst_ni` is low.
- R2: A pixel outside the window (`hcnt_i` not in [X0, X0+WIN_W) or `vcnt_i` not in [Y0, Y0+WIN_H)) outputs `bg_rgb_i` as sampled with those counters.
- R3: A window pixel that is neither a trace pixel nor a grid pixel is black (0).
- R4: With window column c = hcnt_i-X0 and row r = vcnt_i-Y0 (counted from the top), a pixel is a grid pixel when (r mod CELL = 0 and c mod DOT = 0) or (c mod CELL = 0 and r mod DOT = 0), and it shows GRID_RGB.
- R5: With height y = WIN_H-1-r, a pixel shows TRACE_RGB when y lies between the current column's amplitude and the previous column's amplitude, both bounds included. Column 0 uses only its own amplitude.
- R6: A sample is read as an unsigned amplitude measured from the window bottom. Values above WIN_H-1 are treated as WIN_H-1.
- R7: Trace colour overrides grid colour, and grid colour overrides black.
- R8: While `hcnt_i` = h and h+1 lies inside the window's column range, `smp_addr_o` equals h+1-X0. The counters are assumed to advance by one per clock along a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hcnt_i | input | CW | Horizontal pixel counter |
| vcnt_i | input | CW | Vertical pixel counter |
| bg_rgb_i | input | 24 | Colour passed through outside the window |
| smp_addr_o | output | clog2(WIN_W) | Sample memory column address, one pixel ahead |
| smp_data_i | input | SW | Sample memory read data, one cycle after the address |
| rgb_o | output | 24 | Registered pixel colour |

## Verification
The bench builds a 48x30 raster with a 32x20 window at (6,4), an 8-pixel grid cell and a 2-pixel dot pitch. This puts several grid lines, dots and crossings on screen within a small frame. The 20-row window is far below the 8-bit sample range, so clamping at the window top occurs many times per line. The sample table holds flat runs, full-height jumps, zeros and oversized values, so spans that cover grid crossings test the priority order.

// File: rtl/wr_pkg.sv
package wr_pkg;
  typedef logic [23:0] rgb_t;
  localparam rgb_t RGB_BLACK = 24'h000000;
endpackage

// File: rtl/wr_window_map.sv
module wr_window_map #(
  parameter int CW    = 11,
  parameter int X0    = 64,
  parameter int Y0    = 200,
  parameter int WIN_W = 1024,
  parameter int WIN_H = 256,
  parameter int AW    = 10,
  parameter int RW    = 8
) (
  input  logic [CW-1:0] hcnt_i,
  input  logic [CW-1:0] vcnt_i,
  output logic          in_win_o,
  output logic [AW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic [AW-1:0] nxt_addr_o
);
  localparam logic [CW-1:0] X_LO = CW'(X0);
  localparam logic [CW-1:0] X_HI = CW'(X0 + WIN_W);
  localparam logic [CW-1:0] Y_LO = CW'(Y0);
  localparam logic [CW-1:0] Y_HI = CW'(Y0 + WIN_H);

  logic [CW-1:0] h_nxt, h_off, v_off, n_off;
  logic          in_x, in_y, in_nx;

  always_comb begin
    h_nxt = hcnt_i + CW'(1);
    h_off = hcnt_i - X_LO;
    v_off = vcnt_i - Y_LO;
    n_off = h_nxt - X_LO;
    in_x  = (hcnt_i >= X_LO) && (hcnt_i < X_HI);
    in_y  = (vcnt_i >= Y_LO) && (vcnt_i < Y_HI);
    in_nx = (h_nxt >= X_LO) && (h_nxt < X_HI);
  end

  assign in_win_o   = in_x && in_y;
  assign col_o      = AW'(h_off);
  assign row_o      = RW'(v_off);
  assign nxt_addr_o = in_nx ? AW'(n_off) : '0;
endmodule

// File: rtl/wr_grid.sv
module wr_grid #(
  parameter int AW   = 10,
  parameter int RW   = 8,
  parameter int CELL = 32,
  parameter int DOT  = 4
) (
  input  logic [AW-1:0] col_i,
  input  logic [RW-1:0] row_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] C_CELL = AW'(CELL - 1);
  localparam logic [AW-1:0] C_DOT  = AW'(DOT - 1);
  localparam logic [RW-1:0] R_CELL = RW'(CELL - 1);
  localparam logic [RW-1:0] R_DOT  = RW'(DOT - 1);

  logic c_line, c_dot, r_line, r_dot;

  always_comb begin
    c_line = (col_i & C_CELL) == '0;
    c_dot  = (col_i & C_DOT)  == '0;
    r_line = (row_i & R_CELL) == '0;
    r_dot  = (row_i & R_DOT)  == '0;
    hit_o  = (r_line && c_dot) || (c_line && r_dot);
  end
endmodule

// File: rtl/wr_trace.sv
module wr_trace #(
  parameter int RW    = 8,
  parameter int SW    = 8,
  parameter int WIN_H = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_win_i,
  input  logic          first_col_i,
  input  logic [SW-1:0] sample_i,
  input  logic [RW-1:0] row_i,
  output logic          hit_o
);
  localparam logic [SW-1:0] AMAX = SW'(WIN_H - 1);
  localparam logic [RW-1:0] YTOP = RW'(WIN_H - 1);

  logic [RW-1:0] amp, base, lo, hi, y, prev_q;

  always_comb begin
    amp   = (sample_i > AMAX) ? RW'(AMAX) : RW'(sample_i);
    base  = first_col_i ? amp : prev_q;
    lo    = (amp < base) ? amp : base;
    hi    = (amp < base) ? base : amp;
    y     = YTOP - row_i;
    hit_o = in_win_i && (y >= lo) && (y <= hi);
  end

  // remember this column's amplitude for the next column's span
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= '0;
    else if (in_win_i) prev_q <= amp;
  end
endmodule

// File: rtl/wr_scope_raster.sv
module wr_scope_raster
  import wr_pkg::*;
#(
  parameter int   DISP_W    = 1280,
  parameter int   DISP_H    = 720,
  parameter int   CW        = 11,
  parameter int   X0        = 64,
  parameter int   Y0        = 200,
  parameter int   WIN_W     = 1024,
  parameter int   WIN_H     = 256,
  parameter int   CELL      = 32,
  parameter int   DOT       = 4,
  parameter int   SW        = 8,
  parameter rgb_t GRID_RGB  = 24'h808080,
  parameter rgb_t TRACE_RGB = 24'h00ff00
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CW-1:0]            hcnt_i,
  input  logic [CW-1:0]            vcnt_i,
  input  logic [23:0]              bg_rgb_i,
  output logic [$clog2(WIN_W)-1:0] smp_addr_o,
  input  logic [SW-1:0]            smp_data_i,
  output logic [23:0]              rgb_o
);
  localparam int AW = $clog2(WIN_W);
  localparam int RW = $clog2(WIN_H);

  if (Y0 + WIN_H >= DISP_H) begin : g_bad_y
    $error("window bottom edge must stay inside the display height");
  end
  if (X0 + WIN_W > DISP_W) begin : g_bad_x
    $error("window right edge exceeds the display width");
  end
  if ((2 ** CW) <= DISP_W || (2 ** CW) < DISP_H) begin : g_bad_cw
    $error("pixel counter width too small for the display");
  end
  if ((CELL & (CELL - 1)) != 0 || (DOT & (DOT - 1)) != 0) begin : g_bad_pitch
    $error("grid cell and dot pitch must be powers of two");
  end
  if (WIN_H > (2 ** SW)) begin : g_bad_sw
    $error("sample width cannot span the window height");
  end

  logic          in_win, grid_hit, trace_hit;
  logic [AW-1:0] col;
  logic [RW-1:0] row;
  rgb_t          rgb_d, rgb_q;

  wr_window_map #(
    .CW(CW), .X0(X0), .Y0(Y0), .WIN_W(WIN_W), .WIN_H(WIN_H), .AW(AW), .RW(RW)
  ) u_map (
    .hcnt_i    (hcnt_i),
    .vcnt_i    (vcnt_i),
    .in_win_o  (in_win),
    .col_o     (col),
    .row_o     (row),
    .nxt_addr_o(smp_addr_o)
  );

  wr_grid #(.AW(AW), .RW(RW), .CELL(CELL), .DOT(DOT)) u_grid (
    .col_i(col),
    .row_i(row),
    .hit_o(grid_hit)
  );

  wr_trace #(.RW(RW), .SW(SW), .WIN_H(WIN_H)) u_trace (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_win_i   (in_win),
    .first_col_i(col == '0),
    .sample_i   (smp_data_i),
    .row_i      (row),
    .hit_o      (trace_hit)
  );

  always_comb begin
    if (!in_win)        rgb_d = bg_rgb_i;
    else if (trace_hit) rgb_d = TRACE_RGB;
    else if (grid_hit)  rgb_d = GRID_RGB;
    else                rgb_d = RGB_BLACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= RGB_BLACK;
    else         rgb_q <= rgb_d;
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/wr_scope_raster_chk.sv
module wr_scope_raster_chk #(
  parameter int          CW        = 11,
  parameter int          X0        = 64,
  parameter int          Y0        = 200,
  parameter int          WIN_W     = 1024,
  parameter int          WIN_H     = 256,
  parameter int          CELL      = 32,
  parameter int          DOT       = 4,
  parameter int          SW        = 8,
  parameter int          AW        = 10,
  parameter logic [23:0] GRID_RGB  = 24'h808080,
  parameter logic [23:0] TRACE_RGB = 24'h00ff00
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] hcnt_i,
  input logic [CW-1:0] vcnt_i,
  input logic [23:0]   bg_rgb_i,
  input logic [AW-1:0] smp_addr_o,
  input logic [SW-1:0] smp_data_i,
  input logic [23:0]   rgb_o
);
  logic          live_q;
  logic [CW-1:0] h_q, v_q;
  logic [23:0]   bg_q;
  logic [SW-1:0] d_q;
  int            c_p, r_p, amp_p, h_n;
  logic          win_p, grid_p, nx_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      h_q    <= '0;
      v_q    <= '0;
      bg_q   <= '0;
      d_q    <= '0;
    end else begin
      live_q <= 1'b1;
      h_q    <= hcnt_i;
      v_q    <= vcnt_i;
      bg_q   <= bg_rgb_i;
      d_q    <= smp_data_i;
    end
  end

  always_comb begin
    c_p    = int'(h_q) - X0;
    r_p    = int'(v_q) - Y0;
    win_p  = c_p >= 0 && c_p < WIN_W && r_p >= 0 && r_p < WIN_H;
    grid_p = ((r_p % CELL) == 0 && (c_p % DOT) == 0) ||
             ((c_p % CELL) == 0 && (r_p % DOT) == 0);
    amp_p  = (int'(d_q) > WIN_H - 1) ? WIN_H - 1 : int'(d_q);
    h_n    = int'(hcnt_i) + 1 - X0;
    nx_in  = h_n >= 0 && h_n < WIN_W;
  end

  assert_outside_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && !win_p |-> rgb_o == bg_q);

  assert_window_palette_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && win_p |-> (rgb_o == TRACE_RGB || rgb_o == GRID_RGB || rgb_o == 24'h0));

  assert_grid_lit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && win_p && grid_p |-> rgb_o != 24'h0);

  assert_first_col_trace_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && win_p && c_p == 0 && (WIN_H - 1 - r_p) == amp_p |-> rgb_o == TRACE_RGB);

  assert_lookahead_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nx_in |-> int'(smp_addr_o) == h_n);
endmodule

bind wr_scope_raster wr_scope_raster_chk #(
  .CW(CW), .X0(X0), .Y0(Y0), .WIN_W(WIN_W), .WIN_H(WIN_H), .CELL(CELL), .DOT(DOT),
  .SW(SW), .AW($clog2(WIN_W)), .GRID_RGB(GRID_RGB), .TRACE_RGB(TRACE_RGB)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hcnt_i    (hcnt_i),
  .vcnt_i    (vcnt_i),
  .bg_rgb_i  (bg_rgb_i),
  .smp_addr_o(smp_addr_o),
  .smp_data_i(smp_data_i),
  .rgb_o     (rgb_o)
);

// File: tb/sim_wr_scope_raster.sv
`timescale 1ns/1ps
module sim_wr_scope_raster;
  localparam int DW = 48, DH = 30, CW = 6;
  localparam int X0 = 6, Y0 = 4, WW = 32, WH = 20, CELL = 8, DOT = 2;
  localparam logic [23:0] GRID = 24'h808080;
  localparam logic [23:0] TRC  = 24'h00ff00;
  localparam int AW = $clog2(WW);

  // sample table: the stimulus vectors for the sweep
  localparam logic [7:0] SMP [WW] = '{
    8'd0,   8'd0,   8'd5,   8'd19,  8'd255, 8'd3,   8'd10,  8'd10,
    8'd12,  8'd30,  8'd1,   8'd0,   8'd19,  8'd0,   8'd8,   8'd16,
    8'd16,  8'd16,  8'd2,   8'd200, 8'd7,   8'd9,   8'd11,  8'd13,
    8'd18,  8'd4,   8'd0,   8'd20,  8'd6,   8'd15,  8'd8,   8'd24
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] hcnt = '0, vcnt = '0;
  logic [23:0]   bg = '0;
  logic [AW-1:0] addr;
  logic [7:0]    rd_q = '0;
  logic [23:0]   rgb;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) rd_q <= SMP[addr];

  wr_scope_raster #(
    .DISP_W(DW), .DISP_H(DH), .CW(CW), .X0(X0), .Y0(Y0), .WIN_W(WW), .WIN_H(WH),
    .CELL(CELL), .DOT(DOT), .SW(8), .GRID_RGB(GRID), .TRACE_RGB(TRC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hcnt_i(hcnt), .vcnt_i(vcnt), .bg_rgb_i(bg),
    .smp_addr_o(addr), .smp_data_i(rd_q), .rgb_o(rgb)
  );

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic int clampv(int s);
    return (s > WH - 1) ? WH - 1 : s;
  endfunction

  function automatic logic [23:0] model(input int h, input int v, input logic [23:0] b,
                                        output string req);
    int c, r, y, a, p, lo, hi;
    bit tr, gr;
    c = h - X0;
    r = v - Y0;
    if (c < 0 || c >= WW || r < 0 || r >= WH) begin
      req = "R2";
      return b;
    end
    y  = WH - 1 - r;
    a  = clampv(int'(SMP[c]));
    p  = (c == 0) ? a : clampv(int'(SMP[c-1]));
    lo = (a < p) ? a : p;
    hi = (a < p) ? p : a;
    tr = (y >= lo) && (y <= hi);
    gr = ((r % CELL) == 0 && (c % DOT) == 0) || ((c % CELL) == 0 && (r % DOT) == 0);
    if (tr) begin
      if (gr) req = "R7";
      else if (SMP[c] > WH - 1 || (c > 0 && SMP[c-1] > WH - 1)) req = "R6";
      else req = "R5";
      return TRC;
    end
    if (gr) begin
      req = "R4";
      return GRID;
    end
    req = "R3";
    return 24'h0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] exp_q;
    string       req_q;
    bit          pend;

    // R1: reset value
    repeat (3) @(negedge clk);
    check(rgb, 24'h0, "R1 reset");
    @(negedge clk) rst_n = 1'b1;

    // R1: one-cycle latency on an outside pixel
    hcnt = CW'(1); vcnt = CW'(1); bg = 24'habcdef;
    @(negedge clk);
    check(rgb, 24'habcdef, "R1 latency");
    bg = 24'h123456;
    #1 check(rgb, 24'habcdef, "R1 held before edge");
    @(negedge clk);
    check(rgb, 24'h123456, "R1 after edge");

    // R8: lookahead address
    hcnt = CW'(X0 - 1); vcnt = CW'(Y0);
    #1 check(24'(addr), 24'd0, "R8 addr at X0-1");
    hcnt = CW'(X0 + 4);
    #1 check(24'(addr), 24'd5, "R8 addr at X0+4");
    hcnt = CW'(X0 + WW - 2);
    #1 check(24'(addr), 24'(WW - 1), "R8 addr at last col");

    // full-frame sweeps across the sample table
    pend = 0;
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < DH; v++) begin
        for (int h = 0; h < DW; h++) begin
          @(negedge clk);
          if (pend) check(rgb, exp_q, req_q);
          hcnt = CW'(h);
          vcnt = CW'(v);
          bg   = 24'(h * 7 + v * 131 + f * 977 + 1);
          exp_q = model(h, v, bg, req_q);
          pend = 1;
        end
      end
    end
    @(negedge clk);
    check(rgb, exp_q, req_q);

    // R1: reset mid-run returns output to 0
    hcnt = '0; vcnt = '0; bg = 24'hffffff;
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(rgb, 24'h0, "R1 async reset");
    @(negedge clk) rst_n = 1'b1;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule